// File: doc/BRIEF.md
# Calendar Alarm Comparator

This block watches the running calendar of a real-time clock and raises an alarm when the time reaches a programmed target. It holds six alarm bytes: seconds, minutes, hours, weekday, day of month and month. Each byte pairs a 7-bit BCD target with a compare-enable in its top bit. A field whose enable is clear matches any value, so software can, for example, program "every day at 07:30:00" by enabling only the hour, minute and second bytes.

The comparison runs once per seconds update, which the time-keeping logic signals with a one-cycle strobe. On that strobe, if at least one field is enabled and every enabled field equals the current calendar value, a sticky alarm flag is set. The flag stays set until software writes 0 to it. A separate interrupt enable gates the flag onto the interrupt line. The flag is set whether or not the interrupt is enabled, so software can poll it.

A match that persists across several updates fires only once. For example, with only the minute field enabled, the match holds for sixty seconds but fires once. Rewriting any alarm byte re-arms the comparator. Software programs the block through a simple register write port and reads the alarm bytes and the control state back through a combinational read port.

Top module: `alarm_cmp`

## Requirements
- R1: After reset all six alarm bytes read 0, the control register reads 0 (flag clear, interrupt enable clear) and the interrupt output is low.
- R2: A write to register index 8, 9, 10, 11, 12 or 13 stores the full byte in the alarm byte for seconds, minutes, hours, weekday, day of month or month respectively. Reading the same index returns it. Bit 7 is the compare-enable and bits 6:0 are the BCD target (month numbered 1 to 12).
- R3: Register index 14 is the control register. Bit 0 reads the alarm flag, bit 3 reads and writes the interrupt enable, and all other bits read 0.
- R4: On a clock edge where the seconds strobe is high, every enabled field's bits 6:0 equal the current value's bits 6:0, and the comparator is armed, the alarm flag reads 1 from the next cycle on. If any enabled field differs, the flag is not set.
- R5: An alarm byte with bit 7 clear matches any current value, whatever target it holds. Bit 7 of the current calendar values takes no part in the comparison.
- R6: When no alarm byte has bit 7 set, the alarm flag is never set.
- R7: Without the seconds strobe the flag is not set, even while all enabled fields match.
- R8: After a strobe at which the fields matched, the comparator is disarmed. Later strobes set the flag only after a strobe at which they did not match, or after any write to an alarm byte (index 8 to 13), which re-arms it.
- R9: A write to index 14 with bit 0 clear clears the flag. A write with bit 0 set leaves the flag unchanged and never sets it.
- R10: When a flag-setting strobe and a flag-clearing write fall in the same cycle, the flag ends up set.
- R11: The interrupt output is high exactly while both the alarm flag and the interrupt enable are set. The flag is set even while the interrupt enable is clear.
- R12: Writes to indices 0 to 7 and 15 change no alarm byte and no control state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write index |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 4 | Register read index |
| rd_data | output | 8 | Combinational read data for rd_addr |
| sec_tick | input | 1 | One-cycle strobe marking a seconds update |
| cur_fields | input | 48 | Current BCD calendar; byte 0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day of month, 5 month |
| alarm_flag | output | 1 | Sticky alarm flag |
| alarm_irq | output | 1 | Alarm interrupt, flag gated by the enable |

## Verification
The hardest situations to reach from the ports are the ones where a match must not fire. These are a disabled byte holding a target that differs from the current time, a current value with bit 7 set, a still-matching calendar after a fire, and a clearing write in the very cycle of a fire. The bench sweeps all 64 enable masks. In each mask, disabled bytes carry a deliberately wrong target, and in half the masks the current values have bit 7 forced high. For every enabled field it then re-arms and perturbs only that field to prove the miss. Dedicated sequences hold the calendar still across strobes to reach the disarmed state, and drive a strobe and a control write on the same edge.

// File: rtl/alarm_cmp_pkg.sv
package alarm_cmp_pkg;

   // Register indices and control-bit positions that software decodes.
   localparam int ALARM_BASE_DEF = 8;
   localparam int CTRL_IDX_DEF   = 14;
   localparam int FLAG_BIT_DEF   = 0;
   localparam int IE_BIT_DEF     = 3;

   // Control state kept by the flag/enable unit.
   typedef struct packed {
      logic ie;
      logic flag;
   } alarm_ctrl_t;

endpackage

// File: rtl/alarm_cmp_slot.sv
module alarm_cmp_slot #(
   parameter int DATA_W   = 8,
   parameter int ADDR_W   = 4,
   parameter int SLOT_IDX = 8,
   parameter bit CMP_FULL = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [DATA_W-1:0] cur,
   output logic [DATA_W-1:0] slot_val,
   output logic              enabled,
   output logic              hit,
   output logic              written
);
   localparam int EN_BIT = DATA_W - 1;
   localparam int VAL_W  = DATA_W - 1;
   localparam logic [DATA_W-1:0] CMP_MASK =
      CMP_FULL ? {DATA_W{1'b1}} : {1'b0, {VAL_W{1'b1}}};

   logic [DATA_W-1:0] slot_q;
   logic [DATA_W-1:0] target;
   logic              sel;
   logic              eq;

   assign sel = wr_en && (wr_addr == ADDR_W'(SLOT_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   slot_q <= '0;
      else if (sel) slot_q <= wr_data;
   end

   assign target   = {1'b0, slot_q[VAL_W-1:0]};
   assign eq       = ((cur ^ target) & CMP_MASK) == '0;
   assign enabled  = slot_q[EN_BIT];
   assign hit      = !enabled || eq;
   assign written  = sel;
   assign slot_val = slot_q;
endmodule

// File: rtl/alarm_cmp_eval.sv
module alarm_cmp_eval #(
   parameter int NUM_FIELDS = 6
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick,
   input  logic                  rearm,
   input  logic [NUM_FIELDS-1:0] hit_vec,
   input  logic [NUM_FIELDS-1:0] en_vec,
   output logic                  fire,
   output logic                  prev_q
);
   logic match_now;

   assign match_now = (|en_vec) && (&hit_vec);

   // prev_q remembers whether the last evaluated update matched.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prev_q <= 1'b0;
      else if (rearm) prev_q <= 1'b0;
      else if (tick)  prev_q <= match_now;
   end

   assign fire = tick && match_now && !prev_q;
endmodule

// File: rtl/alarm_cmp_ctrl.sv
module alarm_cmp_ctrl
   import alarm_cmp_pkg::*;
#(
   parameter int ADDR_W   = 4,
   parameter int CTRL_IDX = CTRL_IDX_DEF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic              wr_flag_bit,
   input  logic              wr_ie_bit,
   input  logic              fire,
   output alarm_ctrl_t       ctrl_q
);
   logic sel;

   assign sel = wr_en && (wr_addr == ADDR_W'(CTRL_IDX));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else begin
         if (fire)                     ctrl_q.flag <= 1'b1;
         else if (sel && !wr_flag_bit) ctrl_q.flag <= 1'b0;
         if (sel)                      ctrl_q.ie   <= wr_ie_bit;
      end
   end
endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
   import alarm_cmp_pkg::*;
#(
   parameter int NUM_FIELDS = 6,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 4,
   parameter int ALARM_BASE = ALARM_BASE_DEF,
   parameter int CTRL_IDX   = CTRL_IDX_DEF,
   parameter int FLAG_BIT   = FLAG_BIT_DEF,
   parameter int IE_BIT     = IE_BIT_DEF,
   parameter bit CMP_FULL   = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         wr_en,
   input  logic [ADDR_W-1:0]            wr_addr,
   input  logic [DATA_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]            rd_addr,
   output logic [DATA_W-1:0]            rd_data,
   input  logic                         sec_tick,
   input  logic [NUM_FIELDS*DATA_W-1:0] cur_fields,
   output logic                         alarm_flag,
   output logic                         alarm_irq
);
   localparam int LAST_SLOT = ALARM_BASE + NUM_FIELDS - 1;

   // Elaboration-time parameter checks.
   if (DATA_W < 2) begin : g_bad_width
      $error("alarm_cmp: DATA_W must be at least 2");
   end
   if (NUM_FIELDS < 1) begin : g_bad_count
      $error("alarm_cmp: NUM_FIELDS must be at least 1");
   end
   if (CTRL_IDX >= ALARM_BASE && CTRL_IDX <= LAST_SLOT) begin : g_overlap
      $error("alarm_cmp: control index overlaps the alarm bytes");
   end
   if (LAST_SLOT >= (1 << ADDR_W) || CTRL_IDX >= (1 << ADDR_W)) begin : g_range
      $error("alarm_cmp: register index outside ADDR_W");
   end
   if (FLAG_BIT == IE_BIT || FLAG_BIT >= DATA_W || IE_BIT >= DATA_W) begin : g_bits
      $error("alarm_cmp: bad control bit positions");
   end

   logic [DATA_W-1:0]     slot_val [NUM_FIELDS];
   logic [NUM_FIELDS-1:0] en_vec;
   logic [NUM_FIELDS-1:0] hit_vec;
   logic [NUM_FIELDS-1:0] wr_vec;
   logic                  fire;
   logic                  prev_q;
   logic                  ie_q;
   alarm_ctrl_t           ctrl_q;

   for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_slot
      alarm_cmp_slot #(
         .DATA_W   (DATA_W),
         .ADDR_W   (ADDR_W),
         .SLOT_IDX (ALARM_BASE + i),
         .CMP_FULL (CMP_FULL)
      ) i_slot (
         .clk      (clk),
         .rst_n    (rst_n),
         .wr_en    (wr_en),
         .wr_addr  (wr_addr),
         .wr_data  (wr_data),
         .cur      (cur_fields[i*DATA_W +: DATA_W]),
         .slot_val (slot_val[i]),
         .enabled  (en_vec[i]),
         .hit      (hit_vec[i]),
         .written  (wr_vec[i])
      );
   end

   alarm_cmp_eval #(
      .NUM_FIELDS (NUM_FIELDS)
   ) i_eval (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (sec_tick),
      .rearm   (|wr_vec),
      .hit_vec (hit_vec),
      .en_vec  (en_vec),
      .fire    (fire),
      .prev_q  (prev_q)
   );

   alarm_cmp_ctrl #(
      .ADDR_W   (ADDR_W),
      .CTRL_IDX (CTRL_IDX)
   ) i_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en       (wr_en),
      .wr_addr     (wr_addr),
      .wr_flag_bit (wr_data[FLAG_BIT]),
      .wr_ie_bit   (wr_data[IE_BIT]),
      .fire        (fire),
      .ctrl_q      (ctrl_q)
   );

   assign ie_q       = ctrl_q.ie;
   assign alarm_flag = ctrl_q.flag;
   assign alarm_irq  = ctrl_q.flag && ctrl_q.ie;

   always_comb begin
      rd_data = '0;
      for (int i = 0; i < NUM_FIELDS; i++) begin
         if (rd_addr == ADDR_W'(ALARM_BASE + i)) rd_data = slot_val[i];
      end
      if (rd_addr == ADDR_W'(CTRL_IDX)) begin
         rd_data[FLAG_BIT] = ctrl_q.flag;
         rd_data[IE_BIT]   = ctrl_q.ie;
      end
   end
endmodule

// File: rtl/alarm_cmp_chk.sv
module alarm_cmp_chk #(
   parameter int NUM_FIELDS = 6,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 4,
   parameter int CTRL_IDX   = 14,
   parameter int FLAG_BIT   = 0
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  sec_tick,
   input logic                  wr_en,
   input logic [ADDR_W-1:0]     wr_addr,
   input logic [DATA_W-1:0]     wr_data,
   input logic                  alarm_flag,
   input logic                  alarm_irq,
   input logic                  ie_q,
   input logic [NUM_FIELDS-1:0] en_vec,
   input logic                  prev_q
);
   logic ctrl_clear_wr;
   assign ctrl_clear_wr = wr_en && (wr_addr == ADDR_W'(CTRL_IDX)) && !wr_data[FLAG_BIT];

   // R11: interrupt only with the enable set
   p_irq_needs_ie_r11: assert property (@(posedge clk) disable iff (!rst_n)
      alarm_irq |-> ie_q);

   // R11: flag and enable together drive the interrupt
   p_irq_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (alarm_flag && ie_q) |-> alarm_irq);

   // R7: flag rises only after a seconds strobe
   p_set_needs_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(sec_tick));

   // R6: flag rises only with some field enabled
   p_set_needs_field_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> $past(|en_vec));

   // R8: no rise while disarmed
   p_no_retrigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(alarm_flag) |-> !$past(prev_q));

   // R9: flag falls only through a clearing control write
   p_clear_by_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(alarm_flag) |-> $past(ctrl_clear_wr));
endmodule

bind alarm_cmp alarm_cmp_chk #(
   .NUM_FIELDS (NUM_FIELDS),
   .DATA_W     (DATA_W),
   .ADDR_W     (ADDR_W),
   .CTRL_IDX   (CTRL_IDX),
   .FLAG_BIT   (FLAG_BIT)
) i_alarm_cmp_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sec_tick   (sec_tick),
   .wr_en      (wr_en),
   .wr_addr    (wr_addr),
   .wr_data    (wr_data),
   .alarm_flag (alarm_flag),
   .alarm_irq  (alarm_irq),
   .ie_q       (ie_q),
   .en_vec     (en_vec),
   .prev_q     (prev_q)
);

// File: tb/test_alarm_cmp.sv
module test_alarm_cmp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [7:0]  rd_data;
   logic        sec_tick = 1'b0;
   logic [47:0] cur_fields = '0;
   logic        alarm_flag;
   logic        alarm_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [7:0] tgt [6];
   logic [7:0] regv [6];
   logic [7:0] curv [6];

   always #10 clk = ~clk;   // 50 MHz

   alarm_cmp i_alarm_cmp (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sec_tick(sec_tick), .cur_fields(cur_fields),
      .alarm_flag(alarm_flag), .alarm_irq(alarm_irq)
   );

   task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [7:0] d);
      @(negedge clk);
      rd_addr = a;
      #1 d = rd_data;
   endtask

   task automatic tick();
      @(negedge clk);
      sec_tick = 1'b1;
      @(negedge clk);
      sec_tick = 1'b0;
   endtask

   task automatic drive_cur();
      for (int i = 0; i < 6; i++) cur_fields[i*8 +: 8] = curv[i];
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0] d;
      tgt[0] = 8'h45; tgt[1] = 8'h59; tgt[2] = 8'h23;
      tgt[3] = 8'h06; tgt[4] = 8'h31; tgt[5] = 8'h12;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 8; a <= 14; a++) begin
         rd(4'(a), d);
         chk("R1", "reset readback", d, 8'h00);
      end
      chk("R1", "irq after reset", {7'b0, alarm_irq}, 8'h00);

      // R2: alarm byte write/readback
      for (int i = 0; i < 6; i++) wr(4'(8 + i), 8'h80 | tgt[i] | 8'(i));
      for (int i = 0; i < 6; i++) begin
         rd(4'(8 + i), d);
         chk("R2", "alarm byte readback", d, 8'h80 | tgt[i] | 8'(i));
      end

      // R3 and R9: write all ones to control; flag not set, IE set
      wr(4'd14, 8'hFF);
      rd(4'd14, d);
      chk("R3", "control readback", d, 8'h08);
      wr(4'd14, 8'h00);

      // R12: writes to non-register indices are ignored
      for (int a = 0; a < 8; a++) wr(4'(a), 8'hFF);
      wr(4'd15, 8'hFF);
      for (int i = 0; i < 6; i++) begin
         rd(4'(8 + i), d);
         chk("R12", "alarm byte after stray writes", d, 8'h80 | tgt[i] | 8'(i));
      end
      rd(4'd14, d);
      chk("R12", "control after stray writes", d, 8'h00);

      // Sweep all enable masks (R4 R5 R6)
      for (int m = 0; m < 64; m++) begin
         for (int i = 0; i < 6; i++) begin
            if (m[i]) begin regv[i] = 8'h80 | tgt[i]; curv[i] = tgt[i]; end
            else      begin regv[i] = tgt[i];         curv[i] = tgt[i] ^ 8'h01; end
            if (m >= 32) curv[i] = curv[i] | 8'h80;
         end
         drive_cur();
         for (int i = 0; i < 6; i++) wr(4'(8 + i), regv[i]);
         wr(4'd14, 8'h00);
         tick();
         if (m == 0) chk("R6", "no field enabled", {7'b0, alarm_flag}, 8'h00);
         else        chk("R4 R5", $sformatf("mask %0d match", m), {7'b0, alarm_flag}, 8'h01);
         for (int j = 0; j < 6; j++) begin
            if (m[j]) begin
               curv[j] = curv[j] ^ 8'h02;
               drive_cur();
               wr(4'(8 + j), regv[j]);
               wr(4'd14, 8'h00);
               tick();
               chk("R4", $sformatf("mask %0d field %0d differs", m, j), {7'b0, alarm_flag}, 8'h00);
               curv[j] = curv[j] ^ 8'h02;
            end
         end
      end

      // Minute-only alarm for the remaining scenarios
      for (int i = 0; i < 6; i++) begin
         regv[i] = (i == 1) ? (8'h80 | tgt[1]) : 8'h00;
         curv[i] = tgt[i];
      end
      drive_cur();
      for (int i = 0; i < 6; i++) wr(4'(8 + i), regv[i]);
      wr(4'd14, 8'h00);

      // R7: matching time, no strobe
      repeat (5) @(negedge clk);
      chk("R7", "no strobe no set", {7'b0, alarm_flag}, 8'h00);

      // R11: flag sets with IE clear, irq stays low
      tick();
      chk("R11", "flag with IE clear", {7'b0, alarm_flag}, 8'h01);
      chk("R11", "irq with IE clear", {7'b0, alarm_irq}, 8'h00);

      // R9: writing 1 to flag keeps it; enabling IE raises irq
      wr(4'd14, 8'h09);
      chk("R9", "flag kept by writing 1", {7'b0, alarm_flag}, 8'h01);
      chk("R11", "irq with IE set", {7'b0, alarm_irq}, 8'h01);
      wr(4'd14, 8'h08);
      chk("R9", "flag cleared by writing 0", {7'b0, alarm_flag}, 8'h00);
      chk("R11", "irq after clear", {7'b0, alarm_irq}, 8'h00);

      // R8: still matching, disarmed
      tick();
      chk("R8", "no retrigger", {7'b0, alarm_flag}, 8'h00);
      tick();
      chk("R8", "no retrigger second strobe", {7'b0, alarm_flag}, 8'h00);
      wr(4'd9, regv[1]);
      tick();
      chk("R8", "rearmed by alarm write", {7'b0, alarm_flag}, 8'h01);
      wr(4'd14, 8'h00);
      curv[1] = 8'h00; drive_cur();
      tick();
      curv[1] = tgt[1]; drive_cur();
      tick();
      chk("R8", "rearmed by non-matching strobe", {7'b0, alarm_flag}, 8'h01);

      // R10: set and clear in the same cycle
      wr(4'd14, 8'h00);
      wr(4'd9, regv[1]);
      @(negedge clk);
      sec_tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd14; wr_data = 8'h00;
      @(negedge clk);
      sec_tick = 1'b0; wr_en = 1'b0;
      chk("R10", "set wins over clear", {7'b0, alarm_flag}, 8'h01);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule